// File: doc/BRIEF.md
# Multiplexed GPIO Pin Control

This block is the digital control for one I/O pin that several functions share. A configuration word holds the pin's register bits: output data, direction, pull-up, open-drain, and the enables for an alternate serial transmit output, a serial receive input, an external interrupt input, a pin-change interrupt input and an analog channel. A static crystal-output configuration input sits above all of them. From these bits the block drives the pad's high-side, low-side and pull-up enables. It gates the digital input buffer, passes the gated pad level to the receive and interrupt paths, and answers CPU port reads. The CPU read strobe is active low.

The functions are ranked in a fixed order: crystal output first, then the analog channel, then the secondary inputs, then GPIO or transmit output. The gated input is forced to 0 whenever its gate is closed, so downstream logic never sees a floating level. The interrupt outputs pass through a two-flop synchronizer and then a filter. The filter lets a new level through only after it has been stable for `FILT_CYC` clock cycles.

Top module: `mfio_pin_ctrl`

## Requirements
- R1: `pad_pu_en_o` equals the pull-up bit (cfg bit 2) at all times, for either direction setting.
- R2: With direction (cfg bit 1) at 1, open-drain off and no override active, the pad is driven push-pull to the output data bit (cfg bit 0): `pad_hi_en_o` = data and `pad_lo_en_o` = not data. The two enables are never high together.
- R3: With open-drain (cfg bit 3) at 1, `pad_hi_en_o` stays 0. Output data 0 enables the low side, and output data 1 leaves the pad undriven.
- R4: With transmit enable (cfg bit 4) at 1, the pad is driven from `tx_data_i` instead of the output data bit, whatever the direction bit says.
- R5: Receive enable (cfg bit 5), external interrupt enable (cfg bit 6), pin-change enable (cfg bit 7) or analog enable (cfg bit 8) forces both driver enables to 0, overriding direction and transmit.
- R6: With external interrupt or pin-change enable set, the input gate stays open while `rd_n_i` is high, and a pad level reaches `ext_int_o` / `pcint_o`.
- R7: In plain GPIO mode with direction 0, `port_rd_o` returns the pad level only while `rd_n_i` is 0, and returns 0 while `rd_n_i` is 1.
- R8: With analog enable set, the input gate is closed regardless of strobe or interrupt enables. `rx_o`, the interrupt outputs and the direction-0 port read are all 0, and `ana_en_o` is 1.
- R9: `xout_cfg_i` at 1 disables the analog channel (`ana_en_o` 0), every secondary input and output, and both drivers.
- R10: With direction 1, `port_rd_o` returns the output data bit.
- R11: `pad_rd_o` always equals the pad level, whatever the mode or strobe.
- R12: `ext_int_o` changes 2 + `FILT_CYC` clock edges after the gated level changes. A level held for fewer than `FILT_CYC` cycles after synchronization never appears.
- R13: After reset the pin is an input with pull-up on and open-drain and all secondary functions off. A `cfg_we_i` pulse loads `cfg_wdata_i` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load configuration word |
| cfg_wdata_i | input | 9 | Configuration word (bits per R1 to R8) |
| xout_cfg_i | input | 1 | Crystal-output function select |
| tx_data_i | input | 1 | Serial transmit data |
| rd_n_i | input | 1 | CPU port read strobe, active low |
| pad_i | input | 1 | Pad level from the input buffer |
| pad_hi_en_o | output | 1 | High-side driver enable |
| pad_lo_en_o | output | 1 | Low-side driver enable |
| pad_pu_en_o | output | 1 | Pull-up enable |
| ana_en_o | output | 1 | Analog channel connect |
| rx_o | output | 1 | Gated serial receive input |
| ext_int_o | output | 1 | Filtered external interrupt level |
| pcint_o | output | 1 | Filtered pin-change level |
| port_rd_o | output | 1 | Port read data |
| pad_rd_o | output | 1 | Raw pad-data read |

## Verification
Some properties are checked by assertions on every cycle:
- the driver enables are never both high;
- open-drain mode never enables the high side;
- any input function, the analog channel or crystal mode leaves both drivers off;
- the pull-up follows the written bit;
- an idle strobe in GPIO input mode reads 0;
- the analog mode blocks receive and read data.

Only the directed scenarios can show the filter's latency and its rejection of short pulses, the transmit mux, the direction-dependent read-back and the continuous gate that the interrupt enables open.

// File: rtl/mfio_pkg.sv
package mfio_pkg;
  localparam int CFG_W = 9;

  typedef struct packed {
    logic ana_en;
    logic pc_en;
    logic ext_en;
    logic rx_en;
    logic tx_en;
    logic od;
    logic pu;
    logic dir;
    logic dout;
  } mfio_cfg_t;

  typedef struct packed {
    logic xtal;
    logic ana;
    logic sec_in;
    logic tx;
    logic rx;
    logic ext;
    logic pc;
  } mfio_fn_t;
endpackage

// File: rtl/mfio_fn_arb.sv
module mfio_fn_arb
  import mfio_pkg::*;
(
  input  mfio_cfg_t cfg_i,
  input  logic      xtal_i,
  output mfio_fn_t  fn_o
);
  // crystal > analog > secondary input > output functions
  always_comb begin
    fn_o.xtal   = xtal_i;
    fn_o.ana    = cfg_i.ana_en & ~xtal_i;
    fn_o.rx     = cfg_i.rx_en  & ~xtal_i;
    fn_o.ext    = cfg_i.ext_en & ~xtal_i;
    fn_o.pc     = cfg_i.pc_en  & ~xtal_i;
    fn_o.sec_in = fn_o.rx | fn_o.ext | fn_o.pc;
    fn_o.tx     = cfg_i.tx_en  & ~xtal_i;
  end
endmodule

// File: rtl/mfio_drv.sv
module mfio_drv
  import mfio_pkg::*;
(
  input  mfio_cfg_t cfg_i,
  input  mfio_fn_t  fn_i,
  input  logic      tx_data_i,
  output logic      hi_en_o,
  output logic      lo_en_o,
  output logic      pu_en_o
);
  logic drive, val;

  always_comb begin
    drive   = (cfg_i.dir | fn_i.tx) & ~(fn_i.sec_in | fn_i.ana | fn_i.xtal);
    val     = fn_i.tx ? tx_data_i : cfg_i.dout;
    hi_en_o = drive & val & ~cfg_i.od;
    lo_en_o = drive & ~val;
    pu_en_o = cfg_i.pu;
  end
endmodule

// File: rtl/mfio_in_gate.sv
module mfio_in_gate
  import mfio_pkg::*;
(
  input  mfio_fn_t fn_i,
  input  logic     rd_n_i,
  input  logic     pad_i,
  output logic     gated_o,
  output logic     rx_o
);
  logic open_gate;

  always_comb begin
    // analog / crystal close the first gate unconditionally
    open_gate = ~(fn_i.ana | fn_i.xtal) & (fn_i.sec_in | ~rd_n_i);
    gated_o   = open_gate & pad_i;
    rx_o      = gated_o & fn_i.rx;
  end
endmodule

// File: rtl/mfio_sync_filt.sv
module mfio_sync_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4,
  localparam int CNT_W      = $clog2(FILT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [SYNC_STAGES-1:0] sq;
  logic [CNT_W-1:0]       cnt;
  logic                   s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '0;
        else         sq <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '0;
        else         sq <= {sq[SYNC_STAGES-2:0], d_i};
    end
  endgenerate

  assign s = sq[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
      cnt <= '0;
    end else if (s == q_o) begin
      cnt <= '0;
    end else if (cnt == CNT_W'(FILT_CYC - 1)) begin
      q_o <= s;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mfio_pin_ctrl.sv
module mfio_pin_ctrl
  import mfio_pkg::*;
#(
  parameter int FILT_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             xout_cfg_i,
  input  logic             tx_data_i,
  input  logic             rd_n_i,
  input  logic             pad_i,
  output logic             pad_hi_en_o,
  output logic             pad_lo_en_o,
  output logic             pad_pu_en_o,
  output logic             ana_en_o,
  output logic             rx_o,
  output logic             ext_int_o,
  output logic             pcint_o,
  output logic             port_rd_o,
  output logic             pad_rd_o
);
  mfio_cfg_t cfg_q;
  mfio_fn_t  fn;
  logic      gated, lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      cfg_q.pu <= 1'b1;
    end else if (cfg_we_i) begin
      cfg_q <= mfio_cfg_t'(cfg_wdata_i);
    end
  end

  mfio_fn_arb u_arb (.cfg_i(cfg_q), .xtal_i(xout_cfg_i), .fn_o(fn));

  mfio_drv u_drv (
    .cfg_i(cfg_q), .fn_i(fn), .tx_data_i(tx_data_i),
    .hi_en_o(pad_hi_en_o), .lo_en_o(pad_lo_en_o), .pu_en_o(pad_pu_en_o)
  );

  mfio_in_gate u_gate (
    .fn_i(fn), .rd_n_i(rd_n_i), .pad_i(pad_i), .gated_o(gated), .rx_o(rx_o)
  );

  mfio_sync_filt #(.SYNC_STAGES(2), .FILT_CYC(FILT_CYC)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gated), .q_o(lvl)
  );

  assign ext_int_o = lvl & fn.ext;
  assign pcint_o   = lvl & fn.pc;
  assign ana_en_o  = fn.ana;
  assign port_rd_o = cfg_q.dir ? cfg_q.dout : (gated & ~rd_n_i);
  assign pad_rd_o  = pad_i;
endmodule

// File: rtl/mfio_pin_ctrl_chk.sv
module mfio_pin_ctrl_chk
  import mfio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input mfio_cfg_t        cfg_q,
  input logic             xout_cfg_i,
  input logic             rd_n_i,
  input logic             pad_hi_en_o,
  input logic             pad_lo_en_o,
  input logic             pad_pu_en_o,
  input logic             ana_en_o,
  input logic             rx_o,
  input logic             port_rd_o
);
  AST_PU_TRACKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> pad_pu_en_o == $past(cfg_wdata_i[2])); // R1

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pad_hi_en_o && pad_lo_en_o)); // R2

  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.od |-> !pad_hi_en_o); // R3

  AST_INPUT_FN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.rx_en || cfg_q.ext_en || cfg_q.pc_en || cfg_q.ana_en) |-> !pad_hi_en_o && !pad_lo_en_o); // R5

  AST_GPIO_IDLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.dir && rd_n_i) |-> !port_rd_o); // R7

  AST_ANALOG_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ana_en_o |-> !rx_o && (cfg_q.dir || !port_rd_o)); // R8

  AST_XTAL_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xout_cfg_i |-> !ana_en_o && !pad_hi_en_o && !pad_lo_en_o && !rx_o); // R9
endmodule

bind mfio_pin_ctrl mfio_pin_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_q(cfg_q), .xout_cfg_i(xout_cfg_i), .rd_n_i(rd_n_i),
  .pad_hi_en_o(pad_hi_en_o), .pad_lo_en_o(pad_lo_en_o), .pad_pu_en_o(pad_pu_en_o),
  .ana_en_o(ana_en_o), .rx_o(rx_o), .port_rd_o(port_rd_o)
);

// File: tb/mfio_pin_ctrl_tb.sv
module mfio_pin_ctrl_tb;
  localparam int FILT = 4;
  localparam int B_DOUT = 0, B_DIR = 1, B_PU = 2, B_OD = 3, B_TX = 4,
                 B_RX = 5, B_EXT = 6, B_PC = 7, B_ANA = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, xtal = 1'b0, txd = 1'b0, rd_n = 1'b1, pad = 1'b0;
  logic [8:0] wdata = '0;
  logic hi, lo, pu, ana, rx, ext_int, pcint, prd, padrd;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mfio_pin_ctrl #(.FILT_CYC(FILT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .xout_cfg_i(xtal), .tx_data_i(txd), .rd_n_i(rd_n), .pad_i(pad),
    .pad_hi_en_o(hi), .pad_lo_en_o(lo), .pad_pu_en_o(pu), .ana_en_o(ana),
    .rx_o(rx), .ext_int_o(ext_int), .pcint_o(pcint), .port_rd_o(prd), .pad_rd_o(padrd)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; wdata = '0; xtal = 1'b0; txd = 1'b0; rd_n = 1'b1; pad = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
  endtask

  task automatic wr(logic [8:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 pull-up on", pu, 1'b1);
    chk("R13 hi off", hi, 1'b0);
    chk("R13 lo off", lo, 1'b0);
    chk("R13 analog off", ana, 1'b0);
    chk("R13 ext off", ext_int, 1'b0);
  endtask

  task automatic t_pullup();
    do_reset();
    wr(9'(1 << B_PU) | 9'(1 << B_DIR));
    chk("R1 pu with dir=1", pu, 1'b1);
    wr('0);
    chk("R1 pu cleared", pu, 1'b0);
    wr(9'(1 << B_PU));
    chk("R1 pu with dir=0", pu, 1'b1);
  endtask

  task automatic t_pushpull();
    do_reset();
    wr(9'(1 << B_DIR) | 9'(1 << B_DOUT));
    chk("R2 data1 hi", hi, 1'b1);
    chk("R2 data1 lo", lo, 1'b0);
    wr(9'(1 << B_DIR));
    chk("R2 data0 hi", hi, 1'b0);
    chk("R2 data0 lo", lo, 1'b1);
  endtask

  task automatic t_open_drain();
    do_reset();
    wr(9'(1 << B_DIR) | 9'(1 << B_OD) | 9'(1 << B_DOUT));
    chk("R3 od data1 hi", hi, 1'b0);
    chk("R3 od data1 lo", lo, 1'b0);
    wr(9'(1 << B_DIR) | 9'(1 << B_OD));
    chk("R3 od data0 lo", lo, 1'b1);
  endtask

  task automatic t_tx();
    do_reset();
    wr(9'(1 << B_TX) | 9'(1 << B_DOUT));
    txd = 1'b0; #1;
    chk("R4 tx0 lo", lo, 1'b1);
    chk("R4 tx0 hi", hi, 1'b0);
    txd = 1'b1; #1;
    chk("R4 tx1 hi", hi, 1'b1);
  endtask

  task automatic t_sec_off();
    do_reset();
    wr(9'(1 << B_DIR) | 9'(1 << B_RX));
    chk("R5 rx forces lo off", lo, 1'b0);
    wr(9'(1 << B_TX) | 9'(1 << B_DOUT) | 9'(1 << B_PC));
    txd = 1'b1; #1;
    chk("R5 pc forces hi off", hi, 1'b0);
    wr(9'(1 << B_DIR) | 9'(1 << B_DOUT) | 9'(1 << B_ANA));
    chk("R5 analog forces hi off", hi, 1'b0);
  endtask

  task automatic t_gpio_read();
    do_reset();
    pad = 1'b1; rd_n = 1'b1; #1;
    chk("R7 strobe idle reads 0", prd, 1'b0);
    rd_n = 1'b0; #1;
    chk("R7 strobe active reads pad", prd, 1'b1);
    pad = 1'b0; #1;
    chk("R7 strobe active reads pad low", prd, 1'b0);
    rd_n = 1'b1;
    cycles(FILT + 4);
    chk("R7 no int without enable", ext_int, 1'b0);
  endtask

  task automatic t_continuous();
    do_reset();
    wr(9'(1 << B_EXT));
    pad = 1'b1; rd_n = 1'b1;
    cycles(FILT + 4);
    chk("R6 ext sees pad with strobe idle", ext_int, 1'b1);
    do_reset();
    wr(9'(1 << B_PC) | 9'(1 << B_RX));
    pad = 1'b1;
    cycles(FILT + 4);
    chk("R6 pcint sees pad", pcint, 1'b1);
    chk("R6 rx sees pad", rx, 1'b1);
  endtask

  task automatic t_analog();
    do_reset();
    wr(9'(1 << B_ANA) | 9'(1 << B_EXT) | 9'(1 << B_RX));
    pad = 1'b1; rd_n = 1'b0; #1;
    chk("R8 analog en", ana, 1'b1);
    chk("R8 rx blocked", rx, 1'b0);
    chk("R8 read blocked", prd, 1'b0);
    cycles(FILT + 4);
    chk("R8 ext blocked", ext_int, 1'b0);
    rd_n = 1'b1;
  endtask

  task automatic t_xtal();
    do_reset();
    wr(9'(1 << B_ANA) | 9'(1 << B_RX) | 9'(1 << B_EXT));
    xtal = 1'b1; pad = 1'b1; #1;
    chk("R9 analog disabled", ana, 1'b0);
    chk("R9 rx disabled", rx, 1'b0);
    cycles(FILT + 4);
    chk("R9 ext disabled", ext_int, 1'b0);
    wr(9'(1 << B_TX) | 9'(1 << B_DIR));
    txd = 1'b0; #1;
    chk("R9 tx drive disabled", lo, 1'b0);
    xtal = 1'b0;
  endtask

  task automatic t_dir_read();
    do_reset();
    wr(9'(1 << B_DIR) | 9'(1 << B_DOUT));
    pad = 1'b0; rd_n = 1'b1; #1;
    chk("R10 dir1 reads data=1", prd, 1'b1);
    chk("R11 pad data reads pad=0", padrd, 1'b0);
    wr(9'(1 << B_DIR));
    pad = 1'b1; rd_n = 1'b0; #1;
    chk("R10 dir1 reads data=0", prd, 1'b0);
    chk("R11 pad data reads pad=1", padrd, 1'b1);
    rd_n = 1'b1;
    wr(9'(1 << B_ANA));
    chk("R11 pad data in analog mode", padrd, 1'b1);
  endtask

  task automatic t_filter();
    do_reset();
    wr(9'(1 << B_EXT));
    @(negedge clk); pad = 1'b1;
    cycles(1 + FILT);
    chk("R12 not yet after 1+FILT edges", ext_int, 1'b0);
    cycles(1);
    chk("R12 passes after 2+FILT edges", ext_int, 1'b1);
    @(negedge clk); pad = 1'b0;
    cycles(2 + FILT);
    chk("R12 falls after 2+FILT edges", ext_int, 1'b0);
    @(negedge clk); pad = 1'b1;
    cycles(FILT - 1);
    pad = 1'b0;
    for (int i = 0; i < FILT + 4; i++) begin
      @(negedge clk); #1;
      if (ext_int !== 1'b0) begin
        chk("R12 short pulse rejected", ext_int, 1'b0);
        break;
      end
    end
    chk("R12 short pulse rejected end", ext_int, 1'b0);
  endtask

  initial begin
    t_reset();
    t_pullup();
    t_pushpull();
    t_open_drain();
    t_tx();
    t_sec_off();
    t_gpio_read();
    t_continuous();
    t_analog();
    t_xtal();
    t_dir_read();
    t_filter();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule